// File: doc/BRIEF.md
# Multiframe Signaling Debounce Buffer

This block holds the received robbed-bit signaling state of a T1/E1 framer, one 4-bit ABCD word per time-slot channel, for up to 32 channels. Each multiframe the framer presents every channel's ABCD word once, with a strobe that marks the arrival of the D bit. The block records the word as the channel's buffered input. It then decides whether the channel's output word, which downstream logic reads, should change.

Channels can be filtered bit by bit. An output bit then follows a new value only once that value has been seen in two consecutive multiframes, which keeps a single corrupted multiframe off the output. Filtered channels also take their whole buffered input into the output at each end-of-multiframe strobe. Each time a stack-enabled channel's output word changes, the block emits a one-cycle change record for a signaling change stack. A freeze indicator, set and cleared by strobes, stops all output and change-record updates while it is set. Buffered inputs keep updating during a freeze. Any output word can be read by channel number through a registered read port.

Top module: `sig_debounce_buf`

## Requirements
- R1: After synchronous reset, every buffered input word and output word is 0, `frz_ind` is 0 and `chg_valid` is 0.
- R2: For a channel that is not filtered (`debounce_en`=0, or its `stack_en` bit is 0), a D-bit strobe writes `rx_sig` straight into that channel's output word, unless freeze is set.
- R3: Every D-bit strobe writes `rx_sig` into the addressed channel's buffered input word, whether or not freeze is set.
- R4: For a filtered channel (`debounce_en`=1 and its `stack_en` bit is 1), each output bit k becomes `rx_sig[k]` only if `rx_sig[k]` equals bit k of the buffered input word held before the strobe. Otherwise output bit k keeps its value.
- R5: One cycle after a D-bit strobe, `chg_valid` is high for that cycle with `chg_chan` = the channel and `chg_sig` = the new output word. This happens only if the channel's `stack_en` bit is 1, its output word actually changed, and freeze was not set. In every other case `chg_valid` stays 0.
- R6: On an `mf_end` strobe with `debounce_en`=1 and freeze clear, every channel whose `stack_en` bit is 1 copies its buffered input word into its output word. Channels whose `stack_en` bit is 0 keep their output word, and no change record is emitted.
- R7: `frz_on` sets `frz_ind` on the next edge and `frz_off` clears it. When both are high in the same cycle, `frz_ind` becomes 0.
- R8: While `frz_ind` is 1, no output word changes (neither from a strobe nor from `mf_end`) and `chg_valid` stays 0.
- R9: `rd_sig` shows the output word of channel `rd_chan` as it stood at the sampling edge, one cycle after `rd_chan` is presented.
- R10: When a D-bit strobe and `mf_end` occur in the same cycle, the strobed channel's output takes the strobe result. All other eligible channels copy the buffered input word they held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | D-bit strobe: `rx_chan`/`rx_sig` carry one channel's word |
| rx_chan | input | 5 | Channel number of the received word |
| rx_sig | input | 4 | Received ABCD word, bit 3 = A, bit 0 = D |
| mf_end | input | 1 | End-of-multiframe strobe |
| debounce_en | input | 1 | Global enable for bit filtering |
| stack_en | input | 32 | Per-channel stack enable; bit c selects channel c |
| frz_on | input | 1 | Set freeze indicator |
| frz_off | input | 1 | Clear freeze indicator (wins over `frz_on`) |
| frz_ind | output | 1 | Freeze indicator; blocks output updates when high |
| chg_valid | output | 1 | One-cycle change record valid |
| chg_chan | output | 5 | Channel of the change record |
| chg_sig | output | 4 | New output word of the change record |
| rd_chan | input | 5 | Read port channel select |
| rd_sig | output | 4 | Output word of `rd_chan`, one cycle later |

## Verification
The assertions assume that `rx_chan` and `rd_chan` always name a channel below `NUM_CH`. They also assume that `rx_valid`, `mf_end`, `frz_on` and `frz_off` are already settled when the clock edge samples them, so a strobe covers exactly one sampled cycle. The stimulus changes every input on the falling edge and holds each strobe for one full clock period. It only uses channel numbers below 32 and reads results on the falling edge, so it stays within these assumptions. Every expected word follows from the per-bit rule applied to the buffered input and output values that the earlier scenarios left behind. It is never read from inside the design.

// File: rtl/sdb_pkg.sv
// Package: shared word type and the per-bit filter rule for the
// signaling debounce buffer. Assumes a fixed ABCD width of four bits.
package sdb_pkg;
    localparam int SIG_W = 4;

    typedef logic [SIG_W-1:0] sig_t;

    // Per-bit filter: take the incoming bit only where it repeats the
    // previously buffered input bit, otherwise keep the output bit.
    function automatic sig_t filter_word(input sig_t rx, input sig_t held_in,
                                         input sig_t cur_out);
        sig_t res;
        for (int k = 0; k < SIG_W; k++) begin
            res[k] = (rx[k] == held_in[k]) ? rx[k] : cur_out[k];
        end
        return res;
    endfunction
endpackage

// File: rtl/sdb_freeze_ctl.sv
// Module: freeze indicator register. Set by a set strobe, cleared by a
// clear strobe; clear wins when both arrive together. Assumes the
// strobes are synchronous to clk.
module sdb_freeze_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic frz_o
);
    logic frz_q;

    // Purpose: hold the freeze state across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)     frz_q <= 1'b0;
        else if (clr_i) frz_q <= 1'b0;
        else if (set_i) frz_q <= 1'b1;
    end

    assign frz_o = frz_q;

    AST_FRZ_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !frz_o); // R7
    AST_FRZ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> frz_o); // R7
endmodule

// File: rtl/sdb_eval.sv
// Module: combinational update evaluation for one strobed channel.
// Chooses the filtered or the direct path and reports whether the
// output word would change. Assumes the held words belong to the
// strobed channel.
module sdb_eval
    import sdb_pkg::*;
(
    input  sig_t rx_sig_i,
    input  sig_t held_in_i,
    input  sig_t cur_out_i,
    input  logic filt_i,
    output sig_t new_out_o,
    output logic differs_o
);
    sig_t filtered;

    // Purpose: compute the candidate output word and its change flag.
    always_comb begin
        filtered  = filter_word(rx_sig_i, held_in_i, cur_out_i);
        new_out_o = filt_i ? filtered : rx_sig_i;
        differs_o = (new_out_o != cur_out_i);
    end
endmodule

// File: rtl/sdb_store.sv
// Module: per-channel buffered input and output word storage with one
// write channel, a bulk copy mask, a combinational look-up of the write
// channel and a registered read port. Assumes channel numbers are
// below NUM_CH and that the copy mask excludes the write channel.
module sdb_store
    import sdb_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_we_i,
    input  logic              out_we_i,
    input  logic [CHW-1:0]    wr_chan_i,
    input  sig_t              in_wdata_i,
    input  sig_t              out_wdata_i,
    input  logic [NUM_CH-1:0] copy_mask_i,
    output sig_t              look_in_o,
    output sig_t              look_out_o,
    input  logic [CHW-1:0]    rd_chan_i,
    output sig_t              rd_data_o
);
    sig_t in_q  [NUM_CH];
    sig_t out_q [NUM_CH];
    sig_t rd_q;

    // Purpose: update buffered inputs, outputs and bulk copies per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                in_q[c]  <= '0;
                out_q[c] <= '0;
            end
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (in_we_i && wr_chan_i == CHW'(c))
                    in_q[c] <= in_wdata_i;
                if (out_we_i && wr_chan_i == CHW'(c))
                    out_q[c] <= out_wdata_i;
                else if (copy_mask_i[c])
                    out_q[c] <= in_q[c];
            end
        end
    end

    // Purpose: registered read of one output word.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= out_q[rd_chan_i];
    end

    assign look_in_o  = in_q[wr_chan_i];
    assign look_out_o = out_q[wr_chan_i];
    assign rd_data_o  = rd_q;

    AST_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_we_i |=> in_q[$past(wr_chan_i)] == $past(in_wdata_i)); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_we_i && !out_we_i && copy_mask_i == '0) |=>
            $stable(look_out_o) || !$stable(wr_chan_i)); // R8
endmodule

// File: rtl/sig_debounce_buf.sv
// Module: top of the multiframe signaling debounce buffer. Accepts one
// ABCD word per D-bit strobe, updates buffered input and output words,
// applies the end-of-multiframe copy, emits change records and serves
// a registered read port. Assumes rx_chan and rd_chan are below NUM_CH
// and all strobes are single-cycle synchronous pulses.
module sig_debounce_buf
    import sdb_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHW-1:0]    rx_chan,
    input  logic [SIG_W-1:0]  rx_sig,
    input  logic              mf_end,
    input  logic              debounce_en,
    input  logic [NUM_CH-1:0] stack_en,
    input  logic              frz_on,
    input  logic              frz_off,
    output logic              frz_ind,
    output logic              chg_valid,
    output logic [CHW-1:0]    chg_chan,
    output logic [SIG_W-1:0]  chg_sig,
    input  logic [CHW-1:0]    rd_chan,
    output logic [SIG_W-1:0]  rd_sig
);
    logic              frz_q;
    logic              filt_act;
    logic              differs;
    logic              out_we;
    sig_t              new_out;
    sig_t              cur_in;
    sig_t              cur_out;
    logic [NUM_CH-1:0] copy_mask;
    logic              chg_v_q;
    logic [CHW-1:0]    chg_c_q;
    sig_t              chg_s_q;

    sdb_freeze_ctl u_frz (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (frz_on),
        .clr_i (frz_off),
        .frz_o (frz_q)
    );

    assign filt_act = debounce_en && stack_en[rx_chan];

    sdb_eval u_eval (
        .rx_sig_i  (rx_sig),
        .held_in_i (cur_in),
        .cur_out_i (cur_out),
        .filt_i    (filt_act),
        .new_out_o (new_out),
        .differs_o (differs)
    );

    assign out_we = rx_valid && differs && !frz_q;

    // Purpose: per-channel eligibility for the end-of-multiframe copy.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_copy
        assign copy_mask[c] = mf_end && debounce_en && stack_en[c] && !frz_q
                              && !(rx_valid && rx_chan == CHW'(c));
    end

    sdb_store #(.NUM_CH(NUM_CH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_we_i     (rx_valid),
        .out_we_i    (out_we),
        .wr_chan_i   (rx_chan),
        .in_wdata_i  (rx_sig),
        .out_wdata_i (new_out),
        .copy_mask_i (copy_mask),
        .look_in_o   (cur_in),
        .look_out_o  (cur_out),
        .rd_chan_i   (rd_chan),
        .rd_data_o   (rd_sig)
    );

    // Purpose: register one change record per changed stack-enabled channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_v_q <= 1'b0;
            chg_c_q <= '0;
            chg_s_q <= '0;
        end else begin
            chg_v_q <= out_we && stack_en[rx_chan];
            if (out_we) begin
                chg_c_q <= rx_chan;
                chg_s_q <= new_out;
            end
        end
    end

    assign frz_ind   = frz_q;
    assign chg_valid = chg_v_q;
    assign chg_chan  = chg_c_q;
    assign chg_sig   = chg_s_q;

    AST_CHG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> $past(rx_valid)); // R5
    AST_CHG_IS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> chg_sig != $past(cur_out)); // R5
    AST_NO_CHG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        frz_ind |=> !chg_valid); // R8
    AST_CHG_STACK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> $past(stack_en[rx_chan])); // R5
endmodule

// File: tb/tb_sig_debounce_buf.sv
// Directed bench for the signaling debounce buffer: one task per
// scenario, each checking its own results through the ports.
module tb_sig_debounce_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [4:0]  rx_chan = '0;
    logic [3:0]  rx_sig = '0;
    logic        mf_end = 1'b0;
    logic        debounce_en = 1'b0;
    logic [31:0] stack_en = '0;
    logic        frz_on = 1'b0;
    logic        frz_off = 1'b0;
    logic        frz_ind;
    logic        chg_valid;
    logic [4:0]  chg_chan;
    logic [3:0]  chg_sig;
    logic [4:0]  rd_chan = '0;
    logic [3:0]  rd_sig;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sig_debounce_buf dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_chan(rx_chan),
        .rx_sig(rx_sig), .mf_end(mf_end), .debounce_en(debounce_en),
        .stack_en(stack_en), .frz_on(frz_on), .frz_off(frz_off),
        .frz_ind(frz_ind), .chg_valid(chg_valid), .chg_chan(chg_chan),
        .chg_sig(chg_sig), .rd_chan(rd_chan), .rd_sig(rd_sig)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One strobe cycle; returns after the edge with outputs settled.
    task automatic strobe(input logic [4:0] ch, input logic [3:0] s,
                          input logic rv, input logic mf);
        rx_chan = ch; rx_sig = s; rx_valid = rv; mf_end = mf;
        @(negedge clk);
        rx_valid = 1'b0; mf_end = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [4:0] ch, input logic [3:0] exp);
        rd_chan = ch;
        @(negedge clk);
        chk(req, 32'(rd_sig), 32'(exp));
    endtask

    task automatic frz_pulse(input logic on, input logic off);
        frz_on = on; frz_off = off;
        @(negedge clk);
        frz_on = 1'b0; frz_off = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 frz_ind", 32'(frz_ind), 0);
        chk("R1 chg_valid", 32'(chg_valid), 0);
        read_chk("R1 ch0", 5'd0, 4'h0);
        read_chk("R1 ch31", 5'd31, 4'h0);
    endtask

    task automatic t_plain;
        debounce_en = 1'b1;
        strobe(5'd5, 4'hA, 1'b1, 1'b0);
        chk("R5 no record for stack-off channel", 32'(chg_valid), 0);
        read_chk("R2 direct write ch5", 5'd5, 4'hA);
        debounce_en = 1'b0; stack_en[3] = 1'b1;
        strobe(5'd3, 4'h6, 1'b1, 1'b0);
        chk("R5 record valid", 32'(chg_valid), 1);
        chk("R5 record chan", 32'(chg_chan), 3);
        chk("R5 record sig", 32'(chg_sig), 32'h6);
        strobe(5'd3, 4'h6, 1'b1, 1'b0);
        chk("R5 no record when unchanged", 32'(chg_valid), 0);
        read_chk("R2 direct write ch3", 5'd3, 4'h6);
    endtask

    task automatic t_debounce;
        debounce_en = 1'b1; stack_en[7] = 1'b1;
        strobe(5'd7, 4'hF, 1'b1, 1'b0);
        chk("R4 first sighting held", 32'(chg_valid), 0);
        read_chk("R4 out still 0", 5'd7, 4'h0);
        strobe(5'd7, 4'hF, 1'b1, 1'b0);
        chk("R5 repeat makes record", 32'(chg_valid), 1);
        chk("R5 repeat record sig", 32'(chg_sig), 32'hF);
        strobe(5'd7, 4'hB, 1'b1, 1'b0);
        chk("R4 glitch no record", 32'(chg_valid), 0);
        strobe(5'd7, 4'hF, 1'b1, 1'b0);
        read_chk("R4 glitch rejected", 5'd7, 4'hF);
        strobe(5'd7, 4'h5, 1'b1, 1'b0);
        read_chk("R4 mixed bits hold", 5'd7, 4'hF);
        strobe(5'd7, 4'h4, 1'b1, 1'b0);
        chk("R4 per-bit record", 32'(chg_valid), 1);
        chk("R4 per-bit value", 32'(chg_sig), 32'h5);
    endtask

    task automatic t_mfend;
        strobe(5'd0, 4'h0, 1'b0, 1'b1);
        chk("R6 no record on copy", 32'(chg_valid), 0);
        read_chk("R6 R3 copy buffered input ch7", 5'd7, 4'h4);
        read_chk("R6 ch3 unchanged", 5'd3, 4'h6);
    endtask

    task automatic t_freeze;
        frz_pulse(1'b1, 1'b0);
        chk("R7 set", 32'(frz_ind), 1);
        strobe(5'd7, 4'h3, 1'b1, 1'b0);
        chk("R8 no record frozen", 32'(chg_valid), 0);
        strobe(5'd7, 4'h3, 1'b1, 1'b0);
        chk("R8 no record frozen repeat", 32'(chg_valid), 0);
        read_chk("R8 ch7 frozen", 5'd7, 4'h4);
        strobe(5'd5, 4'h1, 1'b1, 1'b0);
        read_chk("R8 ch5 frozen", 5'd5, 4'hA);
        strobe(5'd0, 4'h0, 1'b0, 1'b1);
        read_chk("R8 copy blocked", 5'd7, 4'h4);
        frz_pulse(1'b0, 1'b1);
        chk("R7 clear", 32'(frz_ind), 0);
        strobe(5'd0, 4'h0, 1'b0, 1'b1);
        read_chk("R8 R3 input kept updating", 5'd7, 4'h3);
        read_chk("R6 stack-off channel not copied", 5'd5, 4'hA);
        frz_pulse(1'b1, 1'b0);
        frz_pulse(1'b1, 1'b1);
        chk("R7 clear wins", 32'(frz_ind), 0);
    endtask

    task automatic t_simul;
        stack_en[9] = 1'b1;
        strobe(5'd9, 4'h5, 1'b1, 1'b0);
        chk("R4 ch9 first sighting", 32'(chg_valid), 0);
        read_chk("R4 ch9 held", 5'd9, 4'h0);
        strobe(5'd7, 4'hC, 1'b1, 1'b1);
        chk("R10 no record", 32'(chg_valid), 0);
        read_chk("R10 strobed channel uses strobe result", 5'd7, 4'h3);
        read_chk("R10 other channel copied", 5'd9, 4'h5);
        strobe(5'd0, 4'h0, 1'b0, 1'b1);
        read_chk("R3 buffered input took C", 5'd7, 4'hC);
        rd_chan = 5'd5;
        @(negedge clk);
        rd_chan = 5'd9;
        chk("R9 back-to-back read ch5", 32'(rd_sig), 32'hA);
        @(negedge clk);
        chk("R9 back-to-back read ch9", 32'(rd_sig), 32'h5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_debounce();
        t_mfend();
        t_freeze();
        t_simul();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule